// File: doc/BRIEF.md
# Transmit Word-to-Character Unpacker

This block sits between a transmit FIFO and a serial link transmitter. It takes one 36-bit word at a time. The word is four byte lanes plus one flag bit per lane. The block hands the lanes to the transmitter as single characters, starting with the most significant lane. A character is a data byte or one of two end-of-packet markers: normal or error.

A flag on a lane marks that lane as the end of the buffer. The lanes before it are the last data bytes. The lanes after it are thrown away. Bit 0 of a flagged byte picks the kind of marker. Bit 7 of a flagged byte means that the buffer ends but the packet goes on in the next buffer. In that case no character is sent at all. A word that holds only a marker in its top lane closes a packet whose data ended on a word boundary.

Both sides use a valid/ready handshake. A new word is taken only in the cycle in which the last relevant lane of the held word finishes, so a steady stream runs with no idle cycle between words.

Top module: `tx_unpacker`

## Requirements
- R1: While reset is asserted, and after reset until a word is accepted, `out_valid` is 0 and `in_ready` is 1.
- R2: A word with flag bits 35:32 all zero produces four data characters (`out_ctrl`=0). They come in the order bits 31:24, 23:16, 15:8, 7:0.
- R3: A flagged lane whose bit 7 is 0 produces one control character (`out_ctrl`=1). Its `out_data` is 0x00 when the byte's bit 0 is 0 (normal end) and 0x01 when bit 0 is 1 (error end).
- R4: The flag for lane bits 31:24 is bit 35, for 23:16 it is bit 34, for 15:8 it is bit 33, and for 7:0 it is bit 32. Lanes before the first flagged lane are sent as data. The first flagged lane ends the word, and the lanes after it produce nothing, whatever their flags and bytes hold.
- R5: A flagged lane whose bit 7 is 1 produces no character and ends the word.
- R6: A word flagged only in its top lane produces exactly one character: the marker from R3, or nothing under R5.
- R7: `in_ready` is 1 exactly when no word is held, or when the held word's last relevant lane completes in this cycle. A lane completes when it is accepted by the transmitter, or at once if it is a dropped marker.
- R8: While `out_valid` is 1 and `out_ready` is 0, the character on `out_ctrl`/`out_data` stays unchanged and valid in the next cycle.
- R9: Reset asserted while a word is only partly sent discards the rest of that word. No further character from it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | FIFO word available |
| in_ready | output | 1 | Block takes the word this cycle |
| in_word | input | 36 | Four flag bits (35:32) over four byte lanes (31:0) |
| out_valid | output | 1 | Character available |
| out_ready | input | 1 | Transmitter takes the character this cycle |
| out_ctrl | output | 1 | 1 for an end marker, 0 for data |
| out_data | output | 8 | Data byte, or marker kind (0 normal, 1 error) |

## Verification
The assertions assume that the transmitter and the FIFO obey the handshake. In particular, they assume `in_word` is only looked at in the cycle it is accepted. They assume nothing else about the inputs, so a word may carry any mix of flags in any lanes. The stimulus changes inputs only between clock edges. It drives `in_valid` and `out_ready` at random duty cycles, from always-on to sparse. Its words mix directed marker placements with random flag patterns that include dropped markers and trailing garbage flags. A reference model follows the exact cycle of every `in_ready` and character.

// File: rtl/txu_pkg.sv
package txu_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              is_ctrl;
    logic [BYTE_W-1:0] value;
  } txu_char_t;
endpackage

// File: rtl/txu_lane_pick.sv
module txu_lane_pick
  import txu_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W = LANES * (BYTE_W + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  lane_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              flag_o,
  output logic              last_lane_o
);
  logic [BYTE_W-1:0] lane_byte [LANES];
  logic [LANES-1:0]  lane_flag;

  // Lane 0 is the most significant byte; its flag is the topmost bit.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = word_i[(LANES-1-g)*BYTE_W +: BYTE_W];
    assign lane_flag[g] = word_i[LANES*BYTE_W + (LANES-1-g)];
  end

  always_comb begin
    byte_o      = lane_byte[lane_i];
    flag_o      = lane_flag[lane_i];
    last_lane_o = (lane_i == IDX_W'(LANES-1));
  end
endmodule

// File: rtl/txu_char_form.sv
module txu_char_form
  import txu_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              flag_i,
  output txu_char_t         char_o,
  output logic              drop_o
);
  always_comb begin
    drop_o         = flag_i & byte_i[BYTE_W-1];
    char_o.is_ctrl = flag_i;
    if (flag_i) begin
      char_o.value = {{(BYTE_W-1){1'b0}}, byte_i[0]};
    end else begin
      char_o.value = byte_i;
    end
  end
endmodule

// File: rtl/txu_word_seq.sv
module txu_word_seq
  import txu_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W = LANES * (BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              out_ready,
  output logic              out_valid,
  input  logic              lane_flag,
  input  logic              lane_drop,
  input  logic              lane_is_last,
  output logic [WORD_W-1:0] word_q,
  output logic [IDX_W-1:0]  lane_q
);
  logic              have_q, have_d;
  logic [WORD_W-1:0] word_d;
  logic [IDX_W-1:0]  lane_d;
  logic              word_end, finish, load, advance, fire;

  always_comb begin
    word_end  = lane_flag | lane_is_last;
    out_valid = have_q & ~lane_drop;
    fire      = out_valid & out_ready;
    finish    = have_q & word_end & (lane_drop | out_ready);
    in_ready  = ~have_q | finish;
    load      = in_valid & in_ready;
    advance   = fire & ~word_end;

    have_d = have_q;
    word_d = word_q;
    lane_d = lane_q;
    if (finish) begin
      have_d = 1'b0;
    end
    if (advance) begin
      lane_d = lane_q + IDX_W'(1);
    end
    if (load) begin
      have_d = 1'b1;
      word_d = in_word;
      lane_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      lane_q <= '0;
    end else begin
      have_q <= have_d;
      lane_q <= lane_d;
    end
  end

  // Data register: clock-enabled on load, no reset needed.
  always_ff @(posedge clk) begin
    if (load) begin
      word_q <= word_d;
    end
  end

  p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !have_q |-> !out_valid);

  p_lane_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !lane_flag && !lane_is_last && !in_valid)
    |=> (lane_q == $past(lane_q) + IDX_W'(1)));

  p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && lane_flag && lane_drop) |-> !out_valid);

  p_take_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && have_q) |-> (word_end && (lane_drop || out_ready)));
endmodule

// File: rtl/tx_unpacker.sv
module tx_unpacker
  import txu_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W = LANES * (BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ctrl,
  output logic [BYTE_W-1:0] out_data
);
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  lane_q;
  logic [BYTE_W-1:0] cur_byte;
  logic              cur_flag, cur_last, cur_drop;
  txu_char_t         cur_char;

  txu_word_seq #(.LANES(LANES)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_word     (in_word),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .lane_flag   (cur_flag),
    .lane_drop   (cur_drop),
    .lane_is_last(cur_last),
    .word_q      (word_q),
    .lane_q      (lane_q)
  );

  txu_lane_pick #(.LANES(LANES)) i_pick (
    .word_i     (word_q),
    .lane_i     (lane_q),
    .byte_o     (cur_byte),
    .flag_o     (cur_flag),
    .last_lane_o(cur_last)
  );

  txu_char_form i_form (
    .byte_i(cur_byte),
    .flag_i(cur_flag),
    .char_o(cur_char),
    .drop_o(cur_drop)
  );

  assign out_ctrl = cur_char.is_ctrl;
  assign out_data = cur_char.value;

  p_ctrl_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ctrl) |-> (out_data[BYTE_W-1:1] == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ctrl) && $stable(out_data)));
endmodule

// File: tb/test_tx_unpacker.sv
module test_tx_unpacker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_ctrl;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  logic [8:0]  exp_q[$];
  bit          drop_tail = 0;
  logic [35:0] stim_q[$];
  int          vpct = 100;
  int          rpct = 100;

  tx_unpacker i_tx_unpacker (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_ctrl(out_ctrl), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s/%s %s: actual %0h expected %0h", tag, phase, what, act, exp);
    end
  endtask

  // Expected characters of one word: bit 8 = control, bits 7:0 = value.
  task automatic expand(logic [35:0] w);
    for (int i = 0; i < 4; i++) begin
      logic       f;
      logic [7:0] b;
      f = w[35-i];
      b = w[31-8*i -: 8];
      if (!f) begin
        exp_q.push_back({1'b0, b});
      end else begin
        if (b[7]) drop_tail = 1;
        else      exp_q.push_back({1'b1, 7'b0, b[0]});
        break;
      end
    end
  endtask

  function automatic bit exp_ready();
    if (exp_q.size() == 0 && !drop_tail) return 1;
    if (exp_q.size() == 0 && drop_tail)  return 1;
    if (exp_q.size() == 1 && !drop_tail) return out_ready;
    return 0;
  endfunction

  // One clock: drive at negedge, compare, predict the edge.
  task automatic cycle();
    bit er;
    bit in_fire;
    @(negedge clk);
    in_valid  = (stim_q.size() > 0) && (($urandom % 100) < vpct);
    in_word   = (stim_q.size() > 0) ? stim_q[0] : 36'h0;
    out_ready = (($urandom % 100) < rpct);
    #1;
    er = exp_ready();
    chk(in_ready == er, "R7", "in_ready", in_ready, er);
    chk(out_valid == (exp_q.size() > 0), "R8", "out_valid", out_valid, exp_q.size() > 0);
    if (out_valid && exp_q.size() > 0) begin
      chk({out_ctrl, out_data} == exp_q[0], exp_q[0][8] ? "R3" : "R2", "char",
          {out_ctrl, out_data}, exp_q[0]);
    end
    in_fire = in_valid && er;
    if (exp_q.size() > 0 && out_ready) void'(exp_q.pop_front());
    else if (exp_q.size() == 0 && drop_tail) drop_tail = 0;
    if (in_fire) begin
      expand(stim_q[0]);
      void'(stim_q.pop_front());
    end
  endtask

  task automatic drain(int limit);
    for (int i = 0; i < limit; i++) begin
      if (stim_q.size() == 0 && exp_q.size() == 0 && !drop_tail) break;
      cycle();
    end
    cycle();
    chk(stim_q.size() == 0 && exp_q.size() == 0, "R7", "drained", exp_q.size(), 0);
  endtask

  function automatic logic [35:0] mk(logic [3:0] f, logic [7:0] a, logic [7:0] b,
                                     logic [7:0] c, logic [7:0] d);
    return {f, a, b, c, d};
  endfunction

  initial begin
    // R1: reset state
    #1;
    chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    // R2: plain data words, back to back
    phase = "R2";
    stim_q.push_back(mk(4'h0, 8'h11, 8'h22, 8'h33, 8'h44));
    stim_q.push_back(mk(4'h0, 8'hFF, 8'h80, 8'h01, 8'h00));
    stim_q.push_back(mk(4'h0, 8'hA5, 8'h5A, 8'hC3, 8'h3C));
    drain(100);

    // R3: normal and error markers in each lane
    phase = "R3";
    stim_q.push_back(mk(4'b0100, 8'h61, 8'h00, 8'h77, 8'h77));
    stim_q.push_back(mk(4'b0010, 8'h62, 8'h63, 8'h01, 8'h77));
    stim_q.push_back(mk(4'b0001, 8'h64, 8'h65, 8'h66, 8'h7E));
    stim_q.push_back(mk(4'b0001, 8'h67, 8'h68, 8'h69, 8'h7F));
    drain(100);

    // R4: flags and bytes after the first marker are ignored
    phase = "R4";
    stim_q.push_back(mk(4'b0111, 8'h12, 8'h00, 8'h81, 8'h01));
    stim_q.push_back(mk(4'b0011, 8'h13, 8'h14, 8'h01, 8'h80));
    stim_q.push_back(mk(4'h0, 8'h21, 8'h22, 8'h23, 8'h24));
    drain(100);

    // R5: dropped markers in several lanes, with slow transmitter
    phase = "R5";
    rpct = 50;
    stim_q.push_back(mk(4'b0010, 8'h31, 8'h32, 8'h80, 8'h00));
    stim_q.push_back(mk(4'b0001, 8'h33, 8'h34, 8'h35, 8'h81));
    stim_q.push_back(mk(4'b0100, 8'h36, 8'hFF, 8'h00, 8'h00));
    stim_q.push_back(mk(4'h0, 8'h41, 8'h42, 8'h43, 8'h44));
    drain(200);

    // R6: marker-only words after word-aligned buffers
    phase = "R6";
    rpct = 100;
    stim_q.push_back(mk(4'b1000, 8'h00, 8'h11, 8'h11, 8'h11));
    stim_q.push_back(mk(4'b1000, 8'h01, 8'h11, 8'h11, 8'h11));
    stim_q.push_back(mk(4'b1111, 8'h80, 8'h00, 8'h01, 8'h00));
    stim_q.push_back(mk(4'b1000, 8'h7E, 8'h11, 8'h11, 8'h11));
    drain(100);

    // R7 / R8: random words, random handshake pressure
    phase = "R7";
    for (int k = 0; k < 3; k++) begin
      vpct = (k == 0) ? 100 : (k == 1) ? 60 : 30;
      rpct = (k == 0) ? 40  : (k == 1) ? 100 : 70;
      for (int n = 0; n < 200; n++) begin
        logic [3:0] f;
        f = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
        stim_q.push_back({f, 32'($urandom)});
      end
      drain(20000);
    end

    // R9: reset in the middle of a word
    phase = "R9";
    vpct = 100;
    rpct = 100;
    stim_q.push_back(mk(4'h0, 8'h51, 8'h52, 8'h53, 8'h54));
    cycle();
    cycle();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(out_valid == 0, "R9", "out_valid during reset", out_valid, 0);
    exp_q.delete();
    drop_tail = 0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 0, "R9", "out_valid after mid-word reset", out_valid, 0);
    chk(in_ready == 1, "R9", "in_ready after mid-word reset", in_ready, 1);
    stim_q.push_back(mk(4'b0100, 8'h9A, 8'h01, 8'h00, 8'h00));
    drain(100);

    summary();
  end
endmodule